// File: doc/BRIEF.md
# Line-Store FIFO Reset Pulse Generator

This block sits at the last register stage of a serial digital video output path. It drives an active-low reset strobe for the line-store FIFOs downstream. The strobe drops for exactly the word clock in which a chosen timing-reference identifier word leaves on the output data bus. At all other times it rests HIGH. The output word passes through the same single register stage, so the strobe and the data stay in step.

Upstream logic marks the word about to enter the output register. It raises one marker when that word is the identifier of an end-of-active-video reference and a different marker when it is the identifier of a start-of-active-video reference.

For component standards, a select input picks which of the two identifiers triggers the strobe. For composite standards, a line carries only one identifier. The strobe then falls on whichever marker arrives, and the select input has no effect. The select input and the standard indicator are sampled in the same cycle as the marker. A change to either therefore takes effect from the next identifier word onward.

Top module: `lsf_strobe_top`

## Requirements
- R1: While `rst` is high, `fifo_clr_n` is 1 and `word_out` is all zeros, one clock after each reset edge.
- R2: `word_out` equals the `word_in` value presented one clock earlier.
- R3: With `is_composite`=0 and `pick_eav`=1, `fifo_clr_n` is 0 in the cycle after `eav_id_mark` is 1, and `sav_id_mark` alone gives no pulse.
- R4: With `is_composite`=0 and `pick_eav`=0, `fifo_clr_n` is 0 in the cycle after `sav_id_mark` is 1, and `eav_id_mark` alone gives no pulse.
- R5: With `is_composite`=1, `fifo_clr_n` is 0 in the cycle after either marker is 1, whatever the value of `pick_eav`.
- R6: `fifo_clr_n` is 1 in every cycle that follows a cycle with neither marker set.
- R7: A single-cycle marker yields a low strobe lasting exactly one clock. The select value used is the one sampled with that marker, so a change to `pick_eav` between two identifier words redirects only the later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | WORD_W | Word entering the output register |
| eav_id_mark | input | 1 | `word_in` is an end-of-active-video identifier |
| sav_id_mark | input | 1 | `word_in` is a start-of-active-video identifier |
| is_composite | input | 1 | 1 = composite standard, 0 = component |
| pick_eav | input | 1 | Component only: 1 = strobe on the end identifier, 0 = on the start identifier |
| word_out | output | WORD_W | Registered output word |
| fifo_clr_n | output | 1 | Active-low FIFO reset strobe, aligned with `word_out` |

## Verification
Every result of this block appears one clock after its stimulus: both the output word and the strobe come from a single register stage. The bench drives all inputs on the falling edge. It computes the expected word and strobe from those inputs, and it compares them shortly after the next rising edge, so each check sees exactly the cycle in which the result is due. Directed sequences cover select changes between identifier words, back-to-back markers and both markers at once. Seeded random traffic covers the rest.

// File: rtl/lsf_strobe_pkg.sv
package lsf_strobe_pkg;
  typedef enum logic [1:0] {
    ID_NONE = 2'b00,
    ID_EAV  = 2'b01,
    ID_SAV  = 2'b10,
    ID_BOTH = 2'b11
  } id_kind_t;

  function automatic id_kind_t pack_kind(input logic eav, input logic sav);
    return id_kind_t'({sav, eav});
  endfunction
endpackage

// File: rtl/lsf_id_select.sv
module lsf_id_select
  import lsf_strobe_pkg::*;
(
  input  id_kind_t kind,
  input  logic     is_composite,
  input  logic     pick_eav,
  output logic     fire
);
  always_comb begin
    fire = 1'b0;
    if (is_composite) begin
      fire = (kind != ID_NONE);
    end else begin
      unique case (kind)
        ID_EAV:  fire = pick_eav;
        ID_SAV:  fire = !pick_eav;
        ID_BOTH: fire = 1'b1;
        default: fire = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lsf_out_stage.sv
module lsf_out_stage #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] d_word,
  input  logic              d_fire,
  output logic [WORD_W-1:0] q_word,
  output logic              q_clr_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_word  <= '0;
      q_clr_n <= 1'b1;
    end else begin
      q_word  <= d_word;
      q_clr_n <= !d_fire;
    end
  end
endmodule

// File: rtl/lsf_strobe_top.sv
module lsf_strobe_top
  import lsf_strobe_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              eav_id_mark,
  input  logic              sav_id_mark,
  input  logic              is_composite,
  input  logic              pick_eav,
  output logic [WORD_W-1:0] word_out,
  output logic              fifo_clr_n
);
  id_kind_t kind;
  logic     fire;

  assign kind = pack_kind(eav_id_mark, sav_id_mark);

  lsf_id_select u_sel (
    .kind         (kind),
    .is_composite (is_composite),
    .pick_eav     (pick_eav),
    .fire         (fire)
  );

  lsf_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_word  (word_in),
    .d_fire  (fire),
    .q_word  (word_out),
    .q_clr_n (fifo_clr_n)
  );
endmodule

// File: rtl/lsf_strobe_chk.sv
module lsf_strobe_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_in,
  input logic              eav_id_mark,
  input logic              sav_id_mark,
  input logic              is_composite,
  input logic              pick_eav,
  input logic [WORD_W-1:0] word_out,
  input logic              fifo_clr_n
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (fifo_clr_n && word_out == '0));

  assert_word_delay_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (word_out == $past(word_in)));

  assert_comp_eav_R3: assert property (@(posedge clk) disable iff (rst)
    (!is_composite && pick_eav && eav_id_mark) |=> !fifo_clr_n);

  assert_comp_eav_skip_sav_R3: assert property (@(posedge clk) disable iff (rst)
    (!is_composite && pick_eav && sav_id_mark && !eav_id_mark) |=> fifo_clr_n);

  assert_comp_sav_R4: assert property (@(posedge clk) disable iff (rst)
    (!is_composite && !pick_eav && sav_id_mark) |=> !fifo_clr_n);

  assert_comp_sav_skip_eav_R4: assert property (@(posedge clk) disable iff (rst)
    (!is_composite && !pick_eav && eav_id_mark && !sav_id_mark) |=> fifo_clr_n);

  assert_composite_any_R5: assert property (@(posedge clk) disable iff (rst)
    (is_composite && (eav_id_mark || sav_id_mark)) |=> !fifo_clr_n);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!eav_id_mark && !sav_id_mark) |=> fifo_clr_n);
endmodule

bind lsf_strobe_top lsf_strobe_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/lsf_strobe_top_tb_top.sv
module lsf_strobe_top_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] word_in;
  logic         eav_m, sav_m, comp, pick;
  logic [W-1:0] word_out;
  logic         clr_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lsf_strobe_top #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .word_in(word_in),
    .eav_id_mark(eav_m), .sav_id_mark(sav_m),
    .is_composite(comp), .pick_eav(pick),
    .word_out(word_out), .fifo_clr_n(clr_n)
  );

  function automatic logic exp_clr_n(logic e, logic s, logic c, logic p);
    if (c) return !(e || s);
    if (e && s) return 1'b0;
    if (e) return !p;
    if (s) return p;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string tag_of(logic e, logic s, logic c, logic p);
    if (!e && !s) return "R6";
    if (c) return "R5";
    return p ? "R3" : "R4";
  endfunction

  // drive on falling edge, compare just after the next rising edge
  task automatic step(logic [W-1:0] w, logic e, logic s, logic c, logic p,
                      string req_override = "");
    logic  ec;
    string t;
    @(negedge clk);
    word_in = w; eav_m = e; sav_m = s; comp = c; pick = p;
    ec = exp_clr_n(e, s, c, p);
    t  = (req_override != "") ? req_override : tag_of(e, s, c, p);
    @(posedge clk); #1;
    check(t, {{(W-1){1'b0}}, clr_n}, {{(W-1){1'b0}}, ec});
    check("R2", word_out, w);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; word_in = 10'h3FF; eav_m = 1'b1; sav_m = 1'b1; comp = 1'b0; pick = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {{(W-1){1'b0}}, clr_n}, {{(W-1){1'b0}}, 1'b1});
    check("R1", word_out, '0);
    @(negedge clk);
    rst = 1'b0; eav_m = 1'b0; sav_m = 1'b0;

    // R3: component, end identifier selected
    step(10'h2D8, 1'b1, 1'b0, 1'b0, 1'b1);
    step(10'h200, 1'b0, 1'b1, 1'b0, 1'b1);
    // R4: component, start identifier selected
    step(10'h2AC, 1'b0, 1'b1, 1'b0, 1'b0);
    step(10'h274, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5: composite ignores select
    step(10'h1F0, 1'b1, 1'b0, 1'b1, 1'b0);
    step(10'h1F1, 1'b0, 1'b1, 1'b1, 1'b1);
    step(10'h1F2, 1'b1, 1'b0, 1'b1, 1'b1);
    // R7: single marker gives one-clock pulse, then back high
    step(10'h111, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(10'h112, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    step(10'h113, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    // R7: select flips between identifiers; only later one redirected
    step(10'h120, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    step(10'h121, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(10'h122, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    // both markers together, back-to-back
    step(10'h0AA, 1'b1, 1'b1, 1'b0, 1'b0);
    step(10'h055, 1'b1, 1'b1, 1'b1, 1'b1);

    // reset mid-stream: R1
    @(negedge clk); rst = 1'b1; eav_m = 1'b1; comp = 1'b1;
    @(posedge clk); #1;
    check("R1", {{(W-1){1'b0}}, clr_n}, {{(W-1){1'b0}}, 1'b1});
    check("R1", word_out, '0);
    @(negedge clk); rst = 1'b0;

    // random traffic, markers sparse
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      step(W'($urandom), r == 4'd0, r == 4'd1 || r == 4'd2 && ($urandom & 1) == 1,
           ($urandom_range(0, 3) == 0), ($urandom & 1) == 1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule